// File: doc/BRIEF.md
# Scanline Sprite Evaluator

This block picks the objects that fall on the next video line. It holds a 256-byte object memory, which is 64 entries of four bytes. It holds a 32-byte line buffer with room for eight entries. On each scanline a pulse on `scan_start` clears the line buffer and loads the scan pointer from the object-address register. The scan therefore begins wherever software last left that register, and the pointer can start in the middle of an entry. After the pulse, each `dot_en` cycle counts as one dot. Even dots fetch a byte and odd dots process it. The scan ends after a fixed number of dots.

The pointer follows a set of arithmetic quirks:
- It realigns to a four-byte boundary when a first byte fails the height test.
- It repeats that test on the last byte of a copied entry and clears its low two bits if the test fails.
- It steps by five instead of four once the line buffer is full.
- It stops for good when its ninth bit sets.

A processor data write that arrives during a scan is not stored. It bumps both the scan pointer and the address register. Two flags report the scan result. One shows that the entry at the starting address was in range. The other shows that a ninth in-range entry was found.

Top module: `spr_eval_top`

## Requirements
- R1: After reset, `eval_busy`, `spr0_in_range` and `spr_overflow` are 0, `oam_addr` is 0x00, and every line-buffer byte reads 0xFF.
- R2: A cycle with `scan_start` high sets `eval_busy`, clears both flags, fills the line buffer with 0xFF, and loads the scan pointer and the start address from `oam_addr`.
- R3: A byte `v` is in range when `scanline >= v` and `scanline < v + h`, where `h` is 16 if `tall` is 1 and 8 if `tall` is 0.
- R4: While fewer than eight entries have been found, each odd dot writes the fetched byte into line-buffer byte `4*found + k`. Here `k` is the position of the byte within the current entry, from 0 to 3. An in-range first byte makes the next three fetched bytes follow it, with the pointer stepping by 1 per byte. An out-of-range first byte still lands in byte `4*found`.
- R5: When the first byte is out of range and fewer than eight entries have been found, the pointer becomes `(ptr + 4) & 0x1FC`.
- R6: After the fourth byte of a copied entry, that byte gets the R3 test. If it fails, the pointer has its low two bits cleared.
- R7: `spr0_in_range` sets when an in-range first byte is fetched at a pointer equal to the start address.
- R8: Once eight entries have been found, the line buffer is no longer written. An out-of-range first byte moves the pointer by +5, and an in-range first byte sets `spr_overflow`.
- R9: Once bit 8 of the pointer is set, no further bytes are fetched or written and the flags stop changing.
- R10: A data write (`cpu_data_we`) while `eval_busy` is 1 does not store. It sets `oam_addr` to `(oam_addr + 4) & 0xFC` and the pointer to `(ptr + 4) & 0x1FC`.
- R11: When idle, `cpu_addr_we` loads `oam_addr` from `cpu_wdata`, and `cpu_data_we` stores `cpu_wdata` at `oam_addr` and then increments `oam_addr` modulo 256.
- R12: `eval_busy` stays 1 for exactly EVAL_DOTS `dot_en` cycles after `scan_start` (default 192). Dot parity is counted from 0, so dot 0 is even.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr_we | input | 1 | Load the object-address register from `cpu_wdata` |
| cpu_data_we | input | 1 | Object-memory data write, or the scan-time bump when busy |
| cpu_wdata | input | 8 | Processor write data |
| oam_addr | output | 8 | Object-address register |
| scan_start | input | 1 | Begin evaluation for one line |
| dot_en | input | 1 | One evaluation dot |
| scanline | input | 8 | Line being evaluated |
| tall | input | 1 | 1 selects 16-line objects, 0 selects 8-line objects |
| sec_raddr | input | 5 | Line-buffer read byte address |
| sec_rdata | output | 8 | Line-buffer byte, one cycle after `sec_raddr` |
| spr0_in_range | output | 1 | Entry at the start address was in range |
| spr_overflow | output | 1 | A ninth in-range entry was found |
| eval_busy | output | 1 | Evaluation in progress |

## Verification
The paths that are hardest to reach lie behind a full line buffer: the +5 step, and the overflow hit that depends on it. They only appear after eight copies have completed. The bench loads eight adjacent in-range entries and then places a single Y byte at an offset that only a +5 step can reach. A second run places the byte at the +4 offset instead, and there it must be skipped. The mid-scan bump and the pointer freeze on wrap are reached by firing a processor write at a chosen dot and by starting at 0xFC. The stored byte or its absence then shows up in a later scan. Every run is compared byte by byte with a dot-level model in the bench.

// File: rtl/spr_eval_pkg.sv
package spr_eval_pkg;
  localparam int BYTES_PER_OBJ = 4;
  localparam int SHORT_H = 8;
  localparam int TALL_H  = 16;
  typedef enum logic {PH_FETCH = 1'b0, PH_PROC = 1'b1} dot_phase_e;
endpackage

// File: rtl/spr_oam_ram.sv
module spr_oam_ram #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/spr_range_chk.sv
module spr_range_chk
  import spr_eval_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] line,
  input  logic [W-1:0] ypos,
  input  logic         tall,
  output logic         hit
);
  logic [W:0] diff;
  logic [W:0] height;

  always_comb begin
    diff   = {1'b0, line} - {1'b0, ypos};
    height = tall ? (W+1)'(TALL_H) : (W+1)'(SHORT_H);
    hit    = !diff[W] && (diff < height);
  end
endmodule

// File: rtl/spr_sec_buf.sv
module spr_sec_buf #(
  parameter int SLOTS = 32,
  parameter int AW    = $clog2(SLOTS),
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] slot_q [SLOTS];

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst || clr)                          slot_q[g] <= '1;
      else if (we && waddr == AW'(g))          slot_q[g] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '1;
    else     rdata <= slot_q[raddr];
  end
endmodule

// File: rtl/spr_eval_top.sv
module spr_eval_top
  import spr_eval_pkg::*;
#(
  parameter int OAM_AW    = 8,
  parameter int SEC_SPR   = 8,
  parameter int EVAL_DOTS = 192,
  localparam int SEC_AW   = $clog2(SEC_SPR * BYTES_PER_OBJ)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_addr_we,
  input  logic              cpu_data_we,
  input  logic [7:0]        cpu_wdata,
  output logic [OAM_AW-1:0] oam_addr,
  input  logic              scan_start,
  input  logic              dot_en,
  input  logic [7:0]        scanline,
  input  logic              tall,
  input  logic [SEC_AW-1:0] sec_raddr,
  output logic [7:0]        sec_rdata,
  output logic              spr0_in_range,
  output logic              spr_overflow,
  output logic              eval_busy
);
  localparam int PTR_W   = OAM_AW + 1;
  localparam int FOUND_W = $clog2(SEC_SPR + 1);
  localparam int DOT_W   = $clog2(EVAL_DOTS + 1);
  localparam logic [PTR_W-1:0]  PTR_ALIGN  = {PTR_W{1'b1}} << 2;
  localparam logic [OAM_AW-1:0] ADDR_ALIGN = {OAM_AW{1'b1}} << 2;

  logic [PTR_W-1:0]   ptr_q, ptr_n;
  logic [1:0]         cnt_q, cnt_n;
  logic [FOUND_W-1:0] found_q, found_n;
  logic [OAM_AW-1:0]  addr_q, start_q;
  logic [DOT_W-1:0]   dot_q;
  logic               busy_q, s0_q, s0_n, ovf_q, ovf_n;
  logic [7:0]         byte_q;
  logic               hit, room, dot_go, fetch_go, proc_go, bump;
  dot_phase_e         phase;

  assign phase    = dot_phase_e'(dot_q[0]);
  assign dot_go   = busy_q && dot_en && !scan_start;
  assign fetch_go = dot_go && phase == PH_FETCH && !ptr_q[OAM_AW];
  assign proc_go  = dot_go && phase == PH_PROC  && !ptr_q[OAM_AW];
  assign room     = found_q < FOUND_W'(SEC_SPR);
  assign bump     = busy_q && cpu_data_we && !cpu_addr_we;

  spr_oam_ram #(.AW(OAM_AW), .DW(8)) u_oam (
    .clk   (clk),
    .we    (cpu_data_we && !cpu_addr_we && !busy_q),
    .waddr (addr_q),
    .wdata (cpu_wdata),
    .re    (fetch_go),
    .raddr (ptr_q[OAM_AW-1:0]),
    .rdata (byte_q)
  );

  spr_range_chk #(.W(8)) u_range (
    .line (scanline),
    .ypos (byte_q),
    .tall (tall),
    .hit  (hit)
  );

  spr_sec_buf #(.SLOTS(SEC_SPR * BYTES_PER_OBJ), .AW(SEC_AW), .DW(8)) u_sec (
    .clk   (clk),
    .rst   (rst),
    .clr   (scan_start),
    .we    (proc_go && room),
    .waddr ({found_q[SEC_AW-3:0], cnt_q}),
    .wdata (byte_q),
    .raddr (sec_raddr),
    .rdata (sec_rdata)
  );

  // Pointer walk for one processing dot
  always_comb begin
    ptr_n   = ptr_q;
    cnt_n   = cnt_q;
    found_n = found_q;
    s0_n    = s0_q;
    ovf_n   = ovf_q;
    if (proc_go) begin
      if (cnt_q == 2'd0) begin
        if (hit) begin
          ptr_n = ptr_q + PTR_W'(1);
          cnt_n = 2'd1;
          if (room && ptr_q == {1'b0, start_q}) s0_n = 1'b1;
          if (!room) ovf_n = 1'b1;
        end else if (room) begin
          ptr_n = (ptr_q + PTR_W'(4)) & PTR_ALIGN;
        end else begin
          ptr_n = ptr_q + PTR_W'(5);
        end
      end else begin
        ptr_n = ptr_q + PTR_W'(1);
        cnt_n = cnt_q + 2'd1;
        if (cnt_q == 2'd3) begin
          if (!hit) ptr_n = (ptr_q + PTR_W'(1)) & PTR_ALIGN;
          if (room) found_n = found_q + FOUND_W'(1);
        end
      end
    end
    if (bump) ptr_n = (ptr_q + PTR_W'(4)) & PTR_ALIGN;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q   <= '0;
      cnt_q   <= '0;
      found_q <= '0;
      start_q <= '0;
      dot_q   <= '0;
      busy_q  <= 1'b0;
      s0_q    <= 1'b0;
      ovf_q   <= 1'b0;
    end else if (scan_start) begin
      ptr_q   <= {1'b0, addr_q};
      start_q <= addr_q;
      cnt_q   <= '0;
      found_q <= '0;
      dot_q   <= '0;
      busy_q  <= 1'b1;
      s0_q    <= 1'b0;
      ovf_q   <= 1'b0;
    end else begin
      ptr_q   <= ptr_n;
      cnt_q   <= cnt_n;
      found_q <= found_n;
      s0_q    <= s0_n;
      ovf_q   <= ovf_n;
      if (dot_go) begin
        dot_q <= dot_q + DOT_W'(1);
        if (dot_q == DOT_W'(EVAL_DOTS - 1)) busy_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)              addr_q <= '0;
    else if (cpu_addr_we) addr_q <= cpu_wdata[OAM_AW-1:0];
    else if (cpu_data_we) addr_q <= busy_q ? ((addr_q + OAM_AW'(4)) & ADDR_ALIGN)
                                           : addr_q + OAM_AW'(1);
  end

  assign oam_addr      = addr_q;
  assign spr0_in_range = s0_q;
  assign spr_overflow  = ovf_q;
  assign eval_busy     = busy_q;
endmodule

// File: rtl/spr_eval_chk.sv
module spr_eval_chk #(
  parameter int OAM_AW  = 8,
  parameter int SEC_SPR = 8,
  localparam int PTR_W   = OAM_AW + 1,
  localparam int FOUND_W = $clog2(SEC_SPR + 1)
) (
  input logic               clk,
  input logic               rst,
  input logic               scan_start,
  input logic               cpu_addr_we,
  input logic               cpu_data_we,
  input logic               eval_busy,
  input logic [OAM_AW-1:0]  oam_addr,
  input logic               spr_overflow,
  input logic               spr0_in_range,
  input logic [PTR_W-1:0]   ptr_q,
  input logic [FOUND_W-1:0] found_q
);
  localparam logic [OAM_AW-1:0] AMASK = {OAM_AW{1'b1}} << 2;

  assert_start_clears_R2: assert property (@(posedge clk) disable iff (rst)
    scan_start |=> (eval_busy && !spr_overflow && !spr0_in_range));

  assert_bump_addr_R10: assert property (@(posedge clk) disable iff (rst)
    (eval_busy && cpu_data_we && !cpu_addr_we && !scan_start)
      |=> (oam_addr == (($past(oam_addr) + OAM_AW'(4)) & AMASK)));

  assert_idle_incr_R11: assert property (@(posedge clk) disable iff (rst)
    (!eval_busy && cpu_data_we && !cpu_addr_we && !scan_start)
      |=> (oam_addr == $past(oam_addr) + OAM_AW'(1)));

  assert_ptr_frozen_R9: assert property (@(posedge clk) disable iff (rst)
    (ptr_q[OAM_AW] && !scan_start && !cpu_data_we) |=> $stable(ptr_q));

  assert_ovf_after_eight_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(spr_overflow) |-> (found_q == FOUND_W'(SEC_SPR)));

  assert_found_bound_R8: assert property (@(posedge clk) disable iff (rst)
    found_q <= FOUND_W'(SEC_SPR));
endmodule

bind spr_eval_top spr_eval_chk #(.OAM_AW(OAM_AW), .SEC_SPR(SEC_SPR)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .scan_start    (scan_start),
  .cpu_addr_we   (cpu_addr_we),
  .cpu_data_we   (cpu_data_we),
  .eval_busy     (eval_busy),
  .oam_addr      (oam_addr),
  .spr_overflow  (spr_overflow),
  .spr0_in_range (spr0_in_range),
  .ptr_q         (ptr_q),
  .found_q       (found_q)
);

// File: tb/sim_spr_eval_top.sv
`timescale 1ns/1ps
module sim_spr_eval_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cpu_addr_we = 1'b0, cpu_data_we = 1'b0;
  logic [7:0] cpu_wdata = '0;
  logic [7:0] oam_addr;
  logic       scan_start = 1'b0, dot_en = 1'b0, tall = 1'b0;
  logic [7:0] scanline = '0;
  logic [4:0] sec_raddr = '0;
  logic [7:0] sec_rdata;
  logic       spr0_in_range, spr_overflow, eval_busy;

  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  int m_mem [256];
  int m_sec [32];
  int m_ptr, m_cnt, m_found, m_rd, m_start, m_addr;
  bit m_s0, m_ovf;

  always #4 clk = ~clk;

  spr_eval_top u0 (
    .clk(clk), .rst(rst), .cpu_addr_we(cpu_addr_we), .cpu_data_we(cpu_data_we),
    .cpu_wdata(cpu_wdata), .oam_addr(oam_addr), .scan_start(scan_start),
    .dot_en(dot_en), .scanline(scanline), .tall(tall), .sec_raddr(sec_raddr),
    .sec_rdata(sec_rdata), .spr0_in_range(spr0_in_range),
    .spr_overflow(spr_overflow), .eval_busy(eval_busy)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic read_sec(input int idx, output int v);
    @(negedge clk) sec_raddr = 5'(idx);
    @(negedge clk) v = int'(sec_rdata);
  endtask

  task automatic set_addr(input int a);
    @(negedge clk) cpu_addr_we = 1'b1; cpu_wdata = 8'(a);
    @(negedge clk) cpu_addr_we = 1'b0;
    m_addr = a & 255;
  endtask

  task automatic put_byte(input int v);
    @(negedge clk) cpu_data_we = 1'b1; cpu_wdata = 8'(v);
    @(negedge clk) cpu_data_we = 1'b0;
    m_mem[m_addr] = v & 255;
    m_addr = (m_addr + 1) & 255;
  endtask

  task automatic poke(input int a, input int v);
    set_addr(a);
    put_byte(v);
  endtask

  task automatic fill(input int v);
    set_addr(0);
    for (int i = 0; i < 256; i++) put_byte(v);
  endtask

  task automatic model_dot(input int d, input int line, input int h);
    bit hit;
    if (m_ptr < 256) begin
      if (d % 2 == 0) m_rd = m_mem[m_ptr];
      else begin
        hit = (line >= m_rd) && (line < m_rd + h);
        if (m_found < 8) m_sec[m_found * 4 + m_cnt] = m_rd;
        if (m_cnt == 0) begin
          if (hit) begin
            if (m_found < 8 && m_ptr == m_start) m_s0 = 1'b1;
            if (m_found == 8) m_ovf = 1'b1;
            m_ptr++; m_cnt = 1;
          end else if (m_found < 8) m_ptr = (m_ptr + 4) & 'h1FC;
          else m_ptr = m_ptr + 5;
        end else begin
          m_ptr++; m_cnt++;
          if (m_cnt == 4) begin
            m_cnt = 0;
            if (!hit) m_ptr = m_ptr & 'h1FC;
            if (m_found < 8) m_found++;
          end
        end
      end
    end
  endtask

  // one full scan; a processor write is fired just before dot bump_d (-1: none)
  task automatic run_eval(input int line, input bit is_tall, input int bump_d);
    int h;
    h = is_tall ? 16 : 8;
    @(negedge clk) scan_start = 1'b1; scanline = 8'(line); tall = is_tall;
    for (int i = 0; i < 32; i++) m_sec[i] = 'hFF;
    m_ptr = m_addr; m_start = m_addr; m_cnt = 0; m_found = 0; m_s0 = 0; m_ovf = 0;
    @(negedge clk) scan_start = 1'b0;
    for (int d = 0; d < 192; d++) begin
      if (d == bump_d) begin
        cpu_data_we = 1'b1; cpu_wdata = 8'h05;
        @(negedge clk) cpu_data_we = 1'b0;
        m_ptr = (m_ptr + 4) & 'h1FC;
        m_addr = (m_addr + 4) & 'hFC;
      end
      if (d == 191) check("R12 busy before last dot", int'(eval_busy), 1);
      dot_en = 1'b1;
      @(negedge clk) dot_en = 1'b0;
      model_dot(d, line, h);
    end
    check("R12 busy after last dot", int'(eval_busy), 0);
    check("R10/R11 oam_addr after scan", int'(oam_addr), m_addr);
  endtask

  task automatic compare_model(input string req);
    int v;
    for (int i = 0; i < 32; i++) begin
      read_sec(i, v);
      check(req, v, m_sec[i]);
    end
    check({req, " spr0 flag"}, int'(spr0_in_range), int'(m_s0));
    check({req, " overflow flag"}, int'(spr_overflow), int'(m_ovf));
  endtask

  task automatic t_reset;
    int v;
    check("R1 busy", int'(eval_busy), 0);
    check("R1 spr0", int'(spr0_in_range), 0);
    check("R1 overflow", int'(spr_overflow), 0);
    check("R1 oam_addr", int'(oam_addr), 0);
    read_sec(0, v);  check("R1 buffer byte 0", v, 'hFF);
    read_sec(31, v); check("R1 buffer byte 31", v, 'hFF);
  endtask

  task automatic t_idle_write;
    set_addr('hFF);
    put_byte('h3C);
    check("R11 addr wraps", int'(oam_addr), 0);
    set_addr('h42);
    check("R11 addr load", int'(oam_addr), 'h42);
  endtask

  task automatic t_aligned;
    int v;
    fill('hF0);
    poke('h10, 5); poke('h11, 'hA1); poke('h12, 'hA2); poke('h13, 'hA3);
    poke('h40, 9); poke('h41, 'hB1); poke('h42, 'hB2); poke('h43, 'hB3);
    set_addr(0);
    run_eval(10, 1'b0, -1);
    read_sec(0, v); check("R4 first copy Y", v, 5);
    read_sec(5, v); check("R4 second copy byte1", v, 'hB1);
    read_sec(8, v); check("R4 Y into next slot", v, 'hF0);
    check("R7 spr0 clear when start entry out of range", int'(spr0_in_range), 0);
    compare_model("R5 aligned scan");
  endtask

  task automatic t_tall;
    int v;
    fill('hF0);
    poke(0, 8); poke(1, 'h11);
    set_addr(0);
    run_eval(20, 1'b1, -1);
    read_sec(1, v); check("R3 tall in range", v, 'h11);
    compare_model("R3 tall scan");
    set_addr(0);
    run_eval(20, 1'b0, -1);
    read_sec(1, v); check("R3 short out of range", v, 'hFF);
    compare_model("R3 short scan");
  endtask

  task automatic t_misaligned;
    int v;
    fill('hF0);
    poke(1, 5); poke(2, 'h22); poke(3, 'h33); poke(4, 'hF0); poke(5, 6);
    set_addr(1);
    run_eval(10, 1'b0, -1);
    read_sec(3, v); check("R4 misaligned fourth byte", v, 'hF0);
    read_sec(4, v); check("R6 last byte test realigns", v, 'hF0);
    check("R7 spr0 at start address", int'(spr0_in_range), 1);
    compare_model("R6 misaligned scan");
  endtask

  task automatic t_overflow;
    int v;
    fill('hF0);
    for (int i = 0; i < 8; i++) begin
      poke(i*4, 5); poke(i*4+1, 'h20+i); poke(i*4+2, 'h40+i); poke(i*4+3, 'h60+i);
    end
    poke(37, 5);
    set_addr(0);
    run_eval(10, 1'b0, -1);
    check("R8 overflow via +5 step", int'(spr_overflow), 1);
    read_sec(31, v); check("R8 no writes once full", v, 'h67);
    compare_model("R8 overflow scan");
    poke(37, 'hF0); poke(36, 5);
    set_addr(0);
    run_eval(10, 1'b0, -1);
    check("R8 +4 offset skipped", int'(spr_overflow), 0);
    compare_model("R8 skip scan");
  endtask

  task automatic t_wrap;
    int v;
    fill('hF0);
    poke('hFC, 5); poke(0, 5);
    set_addr('hFC);
    run_eval(10, 1'b0, -1);
    read_sec(0, v); check("R9 copy before wrap", v, 5);
    read_sec(4, v); check("R9 frozen after wrap", v, 'hFF);
    compare_model("R9 wrap scan");
  endtask

  task automatic t_bump;
    int v;
    fill('hF0);
    poke(8, 5); poke(9, 'h99);
    set_addr(6);
    run_eval(10, 1'b0, 2);
    check("R10 addr bumped", int'(oam_addr), 8);
    read_sec(1, v); check("R10 pointer skipped entry", v, 'hFF);
    compare_model("R10 bump scan");
    set_addr(6);
    run_eval(10, 1'b0, -1);
    read_sec(1, v); check("R10 write not stored", v, 'h99);
    compare_model("R10 rescan");
  endtask

  task automatic t_restart;
    set_addr(0);
    @(negedge clk) scan_start = 1'b1;
    @(negedge clk) scan_start = 1'b0;
    check("R2 busy after start", int'(eval_busy), 1);
    check("R2 overflow cleared", int'(spr_overflow), 0);
    for (int d = 0; d < 192; d++) begin
      dot_en = 1'b1;
      @(negedge clk) dot_en = 1'b0;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    m_addr = 0;
    t_reset();
    t_idle_write();
    t_aligned();
    t_tall();
    t_misaligned();
    t_overflow();
    t_restart();
    t_wrap();
    t_bump();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule